// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller with Mode-Steered Upper Bits

This block sits between a CPU bus and a cartridge's ROM and battery-backed RAM. The CPU cannot write to ROM, so writes into the ROM address range (0x0000–0x7FFF) are treated as control commands. The block uses them to keep four pieces of state: a RAM enable flag, a 7-bit ROM bank number, a 2-bit RAM bank number and a banking mode bit.

From that state and the CPU address, the block drives the physical ROM address and the physical RAM address. It also gates RAM reads and writes, and it multiplexes read data back to the CPU.

The block has one 2-bit field whose meaning depends on the mode bit. In mode 0 it supplies the top two bits of the ROM bank. In mode 1 it selects the RAM bank. Each time the mode bit is written, the use that was not selected is cleared. The low five ROM bank bits can never hold zero, so the switchable ROM window never shows bank 0 through those bits.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 and RAM access is disabled.
- R2: A write with address bits 15:13 = 000 and data 0x0A enables RAM access. Data 0x00 disables it. Any other data value leaves the enable as it was.
- R3: A write with address bits 15:13 = 001 loads data bits 4:0 into ROM bank bits 4:0, with the value 0 replaced by 1. ROM bank bits 6:5 are kept.
- R4: A write with address bits 15:13 = 010 uses only data bits 1:0. In mode 0 they load ROM bank bits 6:5 and bits 4:0 are kept. In mode 1 they load the RAM bank number.
- R5: A write with address bits 15:13 = 011 loads the mode from data bit 0. Writing mode 1 clears ROM bank bits 6:5. Writing mode 0 sets the RAM bank to 0.
- R6: ROM mapping works as follows:
  - For CPU addresses 0x0000–0x3FFF, rom_addr is {7'd0, addr[13:0]}.
  - For CPU addresses 0x4000–0x7FFF, rom_addr is {rom bank, addr[13:0]}.
  - For any CPU read in 0x0000–0x7FFF, rom_re is high and cpu_rdata equals rom_rdata.
- R7: RAM mapping works as follows:
  - For CPU addresses 0xA000–0xBFFF, ram_addr is {RAM bank, addr[12:0]}.
  - While RAM access is enabled, ram_re follows reads, ram_we follows writes, and cpu_rdata equals ram_rdata.
  - While RAM access is disabled, ram_re and ram_we stay low and cpu_rdata is 0xFF.
- R8: A control write takes effect at the first rising clock edge at which cpu_wr is high. A write command held without cpu_wr changes nothing. The address outputs follow the address in the same cycle.
- R9: Writes at addresses 0x8000–0xFFFF never change the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, qualified |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_re | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_we | output | 1 | RAM write enable, gated by the RAM enable |
| ram_re | output | 1 | RAM read enable, gated by the RAM enable |
| ram_rdata | input | 8 | RAM read data |

## Verification
A control write is due one edge after it is launched. The bench drives each write just after a falling edge and lets a single rising edge capture it. It then probes the new state during the following low clock phase.

Every address, enable and read-data output is combinational, so its result is due in the same cycle as its address. The bench changes the address in 1 ns steps within one low phase and samples 1 ns after each step. It never lets a probe straddle a rising edge.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;
    localparam int LO_W  = 5;
    localparam int HI_W  = 2;
    localparam int NREG  = 4;

    typedef enum logic [1:0] {
        CMD_RAM_GATE = 2'd0,
        CMD_LO_BANK  = 2'd1,
        CMD_HI_BITS  = 2'd2,
        CMD_MODE_SEL = 2'd3
    } cbc_cmd_e;

    typedef struct packed {
        logic            ram_on;
        logic            mode;
        logic [HI_W-1:0] rom_hi;
        logic [LO_W-1:0] rom_lo;
        logic [HI_W-1:0] ram_bank;
    } cbc_state_t;
endpackage

// File: rtl/cbc_cmd_decode.sv
`timescale 1ns/1ps
module cbc_cmd_decode
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output logic [NREG-1:0]   hit,
    output logic              gate_on,
    output logic              gate_off,
    output logic [LO_W-1:0]   lo_val,
    output logic [HI_W-1:0]   hi_val,
    output logic              mode_val
);
    localparam int SEL_W = 3;

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1 -: SEL_W];

    // one strobe per command region; top select bit must be 0 (ROM area)
    for (genvar r = 0; r < NREG; r++) begin : g_region
        assign hit[r] = wr && (sel == SEL_W'(r));
    end

    assign gate_on  = (wdata == DATA_W'(8'h0A));
    assign gate_off = (wdata == DATA_W'(0));
    assign lo_val   = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];
    assign hi_val   = wdata[HI_W-1:0];
    assign mode_val = wdata[0];
endmodule

// File: rtl/cbc_ctrl_regs.sv
`timescale 1ns/1ps
module cbc_ctrl_regs
    import cbc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] hit,
    input  logic            gate_on,
    input  logic            gate_off,
    input  logic [LO_W-1:0] lo_val,
    input  logic [HI_W-1:0] hi_val,
    input  logic            mode_val,
    output cbc_state_t      state_q
);
    localparam cbc_state_t RESET_ST = '{
        ram_on:   1'b0,
        mode:     1'b0,
        rom_hi:   '0,
        rom_lo:   LO_W'(1),
        ram_bank: '0
    };

    cbc_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (hit[CMD_RAM_GATE]) begin
            if (gate_on) begin
                state_d.ram_on = 1'b1;
            end else if (gate_off) begin
                state_d.ram_on = 1'b0;
            end
        end
        if (hit[CMD_LO_BANK]) begin
            state_d.rom_lo = lo_val;
        end
        if (hit[CMD_HI_BITS]) begin
            if (state_q.mode) begin
                state_d.ram_bank = hi_val;
            end else begin
                state_d.rom_hi = hi_val;
            end
        end
        if (hit[CMD_MODE_SEL]) begin
            state_d.mode = mode_val;
            if (mode_val) begin
                state_d.rom_hi = '0;
            end else begin
                state_d.ram_bank = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_ST;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cbc_addr_map.sv
`timescale 1ns/1ps
module cbc_addr_map
    import cbc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_WIN_W = 14,
    parameter int RAM_WIN_W = 13
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             wr,
    input  logic                             rd,
    input  cbc_state_t                       st,
    input  logic [DATA_W-1:0]                rom_rdata,
    input  logic [DATA_W-1:0]                ram_rdata,
    output logic [LO_W+HI_W+ROM_WIN_W-1:0]   rom_addr,
    output logic                             rom_re,
    output logic [HI_W+RAM_WIN_W-1:0]        ram_addr,
    output logic                             ram_we,
    output logic                             ram_re,
    output logic [DATA_W-1:0]                cpu_rdata
);
    localparam int BANK_W = LO_W + HI_W;
    localparam int RAM_TAG_W = ADDR_W - RAM_WIN_W;
    localparam logic [RAM_TAG_W-1:0] RAM_TAG = RAM_TAG_W'(5);

    logic              in_rom;
    logic              in_ram;
    logic              ram_ok;
    logic [BANK_W-1:0] bank_eff;

    assign in_rom   = (addr[ADDR_W-1] == 1'b0);
    assign in_ram   = (addr[ADDR_W-1:RAM_WIN_W] == RAM_TAG);
    assign ram_ok   = in_ram && st.ram_on;
    assign bank_eff = addr[ROM_WIN_W] ? {st.rom_hi, st.rom_lo} : '0;

    assign rom_addr = {bank_eff, addr[ROM_WIN_W-1:0]};
    assign rom_re   = rd && in_rom;
    assign ram_addr = {st.ram_bank, addr[RAM_WIN_W-1:0]};
    assign ram_we   = wr && ram_ok;
    assign ram_re   = rd && ram_ok;

    always_comb begin
        if (in_rom) begin
            cpu_rdata = rom_rdata;
        end else if (ram_ok) begin
            cpu_rdata = ram_rdata;
        end else begin
            cpu_rdata = '1;
        end
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_WIN_W = 14,
    parameter int RAM_WIN_W = 13,
    localparam int ROM_A_W  = LO_W + HI_W + ROM_WIN_W,
    localparam int RAM_A_W  = HI_W + RAM_WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [ROM_A_W-1:0] rom_addr,
    output logic               rom_re,
    input  logic [DATA_W-1:0]  rom_rdata,
    output logic [RAM_A_W-1:0] ram_addr,
    output logic               ram_we,
    output logic               ram_re,
    input  logic [DATA_W-1:0]  ram_rdata
);
    logic [NREG-1:0] hit;
    logic            gate_on;
    logic            gate_off;
    logic [LO_W-1:0] lo_val;
    logic [HI_W-1:0] hi_val;
    logic            mode_val;
    cbc_state_t      state_q;

    cbc_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr(cpu_addr), .wdata(cpu_wdata), .wr(cpu_wr), .hit(hit),
        .gate_on(gate_on), .gate_off(gate_off), .lo_val(lo_val),
        .hi_val(hi_val), .mode_val(mode_val)
    );

    cbc_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .hit(hit), .gate_on(gate_on),
        .gate_off(gate_off), .lo_val(lo_val), .hi_val(hi_val),
        .mode_val(mode_val), .state_q(state_q)
    );

    cbc_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W)
    ) u_map (
        .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd), .st(state_q),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .rom_addr(rom_addr), .rom_re(rom_re), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_re(ram_re), .cpu_rdata(cpu_rdata)
    );
endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
module cbc_checker
    import cbc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input cbc_state_t  st,
    input logic [20:0] rom_addr,
    input logic        ram_we,
    input logic [7:0]  cpu_rdata
);
    logic [2:0] reg_sel;
    assign reg_sel = cpu_addr[15:13];

    a_r1_lo_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st.rom_lo != '0);

    a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd0 && cpu_wdata == 8'h0A) |=> st.ram_on);

    a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd0 && cpu_wdata == 8'h00) |=> !st.ram_on);

    a_r3_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd1) |=> (st.rom_hi == $past(st.rom_hi)));

    a_r4_mode1_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd2 && st.mode) |=>
            (st.ram_bank == $past(cpu_wdata[1:0]) && $stable(st.rom_hi)));

    a_r5_enter1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd3 && cpu_wdata[0]) |=> (st.mode && st.rom_hi == '0));

    a_r5_enter0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && reg_sel == 3'd3 && !cpu_wdata[0]) |=> (!st.mode && st.ram_bank == '0));

    a_r6_fixed_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == '0));

    a_r7_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
        !st.ram_on |-> !ram_we);

    a_r7_gate_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && reg_sel == 3'd5 && !st.ram_on) |-> (cpu_rdata == 8'hFF));

    a_r9_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (st == $past(st)));
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .st(state_q), .rom_addr(rom_addr),
    .ram_we(ram_we), .cpu_rdata(cpu_rdata)
);

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  rom_rdata = '0;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  cpu_rdata;
    logic [20:0] rom_addr;
    logic        rom_re;
    logic [14:0] ram_addr;
    logic        ram_we;
    logic        ram_re;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the control state
    logic       m_on;
    logic       m_mode;
    logic [1:0] m_hi;
    logic [4:0] m_lo;
    logic [1:0] m_ram;

    always #10 clk = ~clk;

    cart_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_re(rom_re), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_rdata(ram_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] fix_lo(input logic [7:0] d);
        return (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (!a[15]) begin
            case (a[14:13])
                2'd0: begin
                    if (d == 8'h0A) m_on = 1'b1;
                    else if (d == 8'h00) m_on = 1'b0;
                end
                2'd1: m_lo = fix_lo(d);
                2'd2: if (m_mode) m_ram = d[1:0]; else m_hi = d[1:0];
                default: begin
                    m_mode = d[0];
                    if (d[0]) m_hi = 2'd0; else m_ram = 2'd0;
                end
            endcase
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    // probe the state through the address and data outputs within one low phase
    task automatic probe(input string tag);
        logic [13:0] o;
        logic [7:0]  rv;
        o  = 14'($urandom);
        rv = 8'($urandom);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b1; rom_rdata = rv;
        cpu_addr = {2'b01, o};
        #1;
        chk(rom_addr === {m_hi, m_lo, o}, {tag, " R6 switch window rom_addr"},
            32'(rom_addr), 32'({m_hi, m_lo, o}));
        chk(rom_re === 1'b1 && cpu_rdata === rv, {tag, " R6 rom read data"},
            32'(cpu_rdata), 32'(rv));
        cpu_addr = {2'b00, o};
        #1;
        chk(rom_addr === {7'd0, o}, {tag, " R6 fixed window rom_addr"},
            32'(rom_addr), 32'({7'd0, o}));
        cpu_addr = {3'b101, o[12:0]}; ram_rdata = ~rv;
        #1;
        chk(ram_addr === {m_ram, o[12:0]}, {tag, " R7 ram_addr"},
            32'(ram_addr), 32'({m_ram, o[12:0]}));
        chk(cpu_rdata === (m_on ? ~rv : 8'hFF) && ram_re === m_on,
            {tag, " R7 ram read gating"}, 32'({ram_re, cpu_rdata}),
            32'({m_on, (m_on ? ~rv : 8'hFF)}));
        cpu_rd = 1'b0; cpu_wr = 1'b1;
        #1;
        chk(ram_we === m_on, {tag, " R7 ram write gating"}, 32'(ram_we), 32'(m_on));
        cpu_wr = 1'b0;
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            chk(1'b0, "WATCHDOG expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_on = 1'b0; m_mode = 1'b0; m_hi = 2'd0; m_lo = 5'd1; m_ram = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        probe("R1 reset");

        // R2 enable, other values, disable
        do_write(16'h0000, 8'h0A); probe("R2 enable");
        do_write(16'h1FFF, 8'h5A); probe("R2 other value kept on");
        do_write(16'h1000, 8'h00); probe("R2 disable");
        do_write(16'h0123, 8'h0B); probe("R2 other value kept off");
        do_write(16'h0000, 8'h0A);

        // R3 low bits, zero forced to one, upper kept
        do_write(16'h4000, 8'h03);              // R4 mode 0: upper bits = 3
        do_write(16'h2000, 8'h00); probe("R3 zero becomes one");
        do_write(16'h3ABC, 8'hE0); probe("R3 bits 4:0 zero with upper data");
        do_write(16'h2001, 8'hF3); probe("R3 load 0x13 keeps upper");

        // R4 / R5 mode steering
        do_write(16'h5FFF, 8'hFE); probe("R4 mode0 only bits 1:0");
        do_write(16'h6000, 8'h01); probe("R5 enter mode1 clears upper");
        do_write(16'h4000, 8'h03); probe("R4 mode1 sets ram bank");
        do_write(16'h6000, 8'h03); probe("R5 mode1 rewrite keeps ram bank");
        do_write(16'h7FFF, 8'h02); probe("R5 enter mode0 clears ram bank");

        // R9 writes above the ROM area
        do_write(16'hA000, 8'h0A); do_write(16'hC000, 8'h00);
        do_write(16'hE000, 8'h01); do_write(16'h8000, 8'h1F);
        probe("R9 high writes ignored");

        // R8 write command without strobe changes nothing
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_wdata = 8'h07; cpu_wr = 1'b0;
        @(posedge clk);
        probe("R8 no strobe no change");
        do_write(16'h2000, 8'h07); probe("R8 strobed write lands at edge");

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            if ($urandom_range(0, 3) != 0) a[15] = 1'b0;
            d = 8'($urandom);
            if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) != 0) ? 8'h0A : 8'h00;
            do_write(a, d);
            probe("R3 R4 R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule